// File: doc/BRIEF.md
# Keyboard Beep Tone Generator

This block produces a square-wave audio tone for a keyboard beeper. A counter runs all the time and advances once every two system clocks. The beep output copies one bit of that counter. Picking a higher bit gives a lower pitch. Software writes two registers. A control word turns the tone on and off. A select word holds a one-hot field that names the counter bit to use as the tap.

The system clock can be slowed to one half or one thirty-second of full speed. A frequency-mode input tells the block which rate is in force. The block then moves the effective tap down by one or five bit positions, so the pitch heard stays the same. A two-state machine decides whether the output may follow the tap. In `ST_SILENT` the output is held low. In `ST_TONE` the output follows the tap.

- The `start` transition (`ST_SILENT` to `ST_TONE`) is taken when the beep is enabled and a valid tap is present.
- The `stop` transition (`ST_TONE` to `ST_SILENT`) is taken when either of those conditions goes away.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the enable is off, the select field is zero and `beep_out` is low.
- R2: A write with `wr_sel`=0 loads the enable from `wr_data` bit 0. Bits 1 and above of that word have no effect.
- R3: The counter advances by one on every second clock after reset. With effective tap k, `beep_out` equals counter bit k and has a period of 2^(k+2) clocks. With the default field base of 10, the lowest select bit gives a period of 2^12 clocks.
- R4: A write with `wr_sel`=1 loads the select field from `wr_data` bits [SEL_LSB+SEL_W-1:SEL_LSB]. Field bit i names counter bit SEL_LSB+i. Data bits outside the field are ignored.
- R5: If more than one select bit is set, the lowest set bit picks the tap.
- R6: If no select bit is set, `beep_out` stays low.
- R7: With `freq_mode`=1 (half speed), the effective tap is one bit below the selected bit, and never below bit 0.
- R8: With `freq_mode`=2 (1/32 speed), the effective tap is five bits below the selected bit, and saturates at bit 0. With `freq_mode`=0 or 3, the selected bit is used unchanged.
- R9: While the enable is off, `beep_out` is low. The counter keeps running, so after re-enabling, the tone continues in the phase it would have had anyway.
- R10: The state machine enters `ST_TONE` one clock after enable and a valid tap are both present. It returns to `ST_SILENT` one clock after either is gone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register choice: 0 selects control, 1 selects tap select |
| wr_data | input | 32 | Write data |
| freq_mode | input | 2 | Current clock rate: 0 full, 1 half, 2 one thirty-second, 3 full |
| beep_out | output | 1 | Square-wave tone output |

## Verification
The bench builds the block with a 12-bit counter, a select field at bits 4 to 8, and the default shifts of 1 and 5. These values keep the longest tone period at 1024 clocks. They also let a low tap combined with the 1/32 shift reach the saturation at bit 0. The bench keeps its own cycle count from reset and derives the counter value from it. This lets it compare the output against the expected bit on every cycle of a window, including after a re-enable, where phase continuity is the point of the check.

// File: rtl/beep_pkg.sv
`timescale 1ns/1ps
package beep_pkg;
    localparam logic [1:0] FM_FULL   = 2'd0;
    localparam logic [1:0] FM_HALF   = 2'd1;
    localparam logic [1:0] FM_SLOW32 = 2'd2;

    typedef enum logic {
        ST_SILENT = 1'b0,
        ST_TONE   = 1'b1
    } beep_state_t;
endpackage

// File: rtl/beep_ctrl_regs.sv
`timescale 1ns/1ps
module beep_ctrl_regs #(
    parameter int DATA_W  = 32,
    parameter int SEL_LSB = 10,
    parameter int SEL_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_q,
    output logic [SEL_W-1:0]  sel_q
);
    // only bit 0 and the select field are stored; the rest is dropped
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                sel_q <= wr_data[SEL_LSB +: SEL_W];
            end else begin
                en_q <= wr_data[0];
            end
        end
    end
endmodule

// File: rtl/beep_half_rate_ctr.sv
`timescale 1ns/1ps
module beep_half_rate_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ph_q,
    output logic [CNT_W-1:0] cnt_q
);
    // phase bit acts as a clock enable at half the system rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/beep_tap_map.sv
`timescale 1ns/1ps
module beep_tap_map
    import beep_pkg::*;
#(
    parameter int SEL_LSB    = 10,
    parameter int SEL_W      = 9,
    parameter int TAP_W      = 5,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       mode,
    output logic [TAP_W-1:0] raw_tap,
    output logic [TAP_W-1:0] eff_tap,
    output logic             tap_valid
);
    logic [TAP_W-1:0] shamt;

    // lowest set select bit wins: scan downward so it is assigned last
    always_comb begin
        raw_tap   = '0;
        tap_valid = 1'b0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel[i]) begin
                raw_tap   = TAP_W'(SEL_LSB + i);
                tap_valid = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (mode)
            FM_HALF:   shamt = TAP_W'(HALF_SHIFT);
            FM_SLOW32: shamt = TAP_W'(SLOW_SHIFT);
            default:   shamt = '0;
        endcase
        eff_tap = (raw_tap >= shamt) ? (raw_tap - shamt) : '0;
    end
endmodule

// File: rtl/beep_tone_gen.sv
`timescale 1ns/1ps
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 20,
    parameter int SEL_LSB    = 10,
    parameter int SEL_W      = 9,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        freq_mode,
    output logic              beep_out
);
    localparam int TAP_W = $clog2(CNT_W);

    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAP_W-1:0] raw_tap;
    logic [TAP_W-1:0] eff_tap;
    logic             tap_valid;
    beep_state_t      state_q, state_d;

    beep_ctrl_regs #(
        .DATA_W (DATA_W),
        .SEL_LSB(SEL_LSB),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .en_q   (en_q),
        .sel_q  (sel_q)
    );

    beep_half_rate_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .ph_q (ph_q),
        .cnt_q(cnt_q)
    );

    beep_tap_map #(
        .SEL_LSB   (SEL_LSB),
        .SEL_W     (SEL_W),
        .TAP_W     (TAP_W),
        .HALF_SHIFT(HALF_SHIFT),
        .SLOW_SHIFT(SLOW_SHIFT)
    ) u_map (
        .sel      (sel_q),
        .mode     (freq_mode),
        .raw_tap  (raw_tap),
        .eff_tap  (eff_tap),
        .tap_valid(tap_valid)
    );

    // next-state logic: start / stop transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SILENT: if (en_q && tap_valid)    state_d = ST_TONE;
            ST_TONE:   if (!en_q || !tap_valid)  state_d = ST_SILENT;
            default:   state_d = ST_SILENT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SILENT;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        beep_out = (state_q == ST_TONE) && cnt_q[eff_tap];
    end
endmodule

// File: rtl/beep_tone_chk.sv
`timescale 1ns/1ps
module beep_tone_chk
    import beep_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int SEL_W = 9,
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic [SEL_W-1:0] sel_q,
    input logic             ph_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [TAP_W-1:0] raw_tap,
    input logic [TAP_W-1:0] eff_tap,
    input logic             tap_valid,
    input beep_state_t      state_q,
    input logic             beep_out
);
    // R9
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !beep_out);

    // R6
    empty_sel_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |=> !beep_out);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_q |=> $stable(cnt_q));

    // R8
    eff_tap_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_tap <= raw_tap);

    // R10
    tone_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tap_valid) |=> (state_q == ST_TONE));
endmodule

bind beep_tone_gen beep_tone_chk #(
    .CNT_W(CNT_W),
    .SEL_W(SEL_W),
    .TAP_W(TAP_W)
) u_beep_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .sel_q    (sel_q),
    .ph_q     (ph_q),
    .cnt_q    (cnt_q),
    .raw_tap  (raw_tap),
    .eff_tap  (eff_tap),
    .tap_valid(tap_valid),
    .state_q  (state_q),
    .beep_out (beep_out)
);

// File: tb/test_beep_tone_gen.sv
`timescale 1ns/1ps
module test_beep_tone_gen;
    localparam int CNT_W   = 12;
    localparam int SEL_LSB = 4;
    localparam int SEL_W   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  freq_mode = 2'd0;
    logic        beep_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    beep_tone_gen #(
        .CNT_W  (CNT_W),
        .SEL_LSB(SEL_LSB),
        .SEL_W  (SEL_W)
    ) i_beep_tone_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .freq_mode(freq_mode),
        .beep_out (beep_out)
    );

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
    endtask

    // compare output against the counter model for n cycles
    task automatic check_window(input string rq, input int tap, input bit silent, input int n);
        int bad = 0;
        logic exp_v;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            exp_v = silent ? 1'b0 : (((cyc >> (tap + 1)) & 1) != 0);
            if (beep_out !== exp_v) begin
                if (bad == 0)
                    $display("FAIL %s cycle %0d actual %0b expected %0b", rq, cyc, beep_out, exp_v);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic check_period(input string rq, input int exp_p);
        int lim = 0;
        int p = 0;
        while (beep_out !== 1'b0 && lim < 5000) begin @(negedge clk); lim++; end
        while (beep_out !== 1'b1 && lim < 5000) begin @(negedge clk); lim++; end
        while (beep_out !== 1'b0 && lim < 5000) begin @(negedge clk); lim++; p++; end
        while (beep_out !== 1'b1 && lim < 5000) begin @(negedge clk); lim++; p++; end
        checks++;
        if (p != exp_p) begin
            errors++;
            $display("FAIL %s period actual %0d expected %0d", rq, p, exp_p);
        end
    endtask

    task automatic t_reset;
        // R1: silent out of reset with nothing programmed
        check_window("R1", 0, 1'b1, 40);
    endtask

    task automatic t_enable_bit;
        write_reg(1'b1, 32'h1 << SEL_LSB);
        write_reg(1'b0, 32'hFFFF_FFFE);        // R2: only bit 0 enables
        check_window("R2", 0, 1'b1, 80);
        write_reg(1'b0, 32'h0000_0001);
        check_window("R2", SEL_LSB, 1'b0, 200);
    endtask

    task automatic t_period;
        // R3: tap k gives period 2^(k+2)
        write_reg(1'b1, 32'h1 << SEL_LSB);
        check_period("R3", 64);
        write_reg(1'b1, 32'h10 << SEL_LSB);
        check_period("R3", 1024);
    endtask

    task automatic t_field;
        // R4: bits outside [8:4] do not select anything
        write_reg(1'b1, 32'hFFFF_FE0F);
        check_window("R4", 0, 1'b1, 80);
        write_reg(1'b1, 32'h4 << SEL_LSB);
        check_window("R4", SEL_LSB + 2, 1'b0, 600);
    endtask

    task automatic t_multi;
        // R5: field 10110 -> lowest set is bit 1 -> tap 5
        write_reg(1'b1, 32'h16 << SEL_LSB);
        check_window("R5", SEL_LSB + 1, 1'b0, 600);
    endtask

    task automatic t_none;
        // R6
        write_reg(1'b1, 32'h0);
        check_window("R6", 0, 1'b1, 200);
    endtask

    task automatic t_half;
        // R7: tap 6 at half speed -> tap 5
        write_reg(1'b1, 32'h4 << SEL_LSB);
        freq_mode = 2'd1;
        check_window("R7", 5, 1'b0, 600);
        check_period("R7", 128);
    endtask

    task automatic t_slow;
        // R8: tap 8 at 1/32 -> tap 3; tap 4 -> saturates at 0
        write_reg(1'b1, 32'h10 << SEL_LSB);
        freq_mode = 2'd2;
        check_window("R8", 3, 1'b0, 300);
        write_reg(1'b1, 32'h1 << SEL_LSB);
        check_window("R8", 0, 1'b0, 100);
        check_period("R8", 4);
        freq_mode = 2'd3;
        check_window("R8", SEL_LSB, 1'b0, 300);
        freq_mode = 2'd0;
    endtask

    task automatic t_disable;
        // R9 / R10: silence while off, phase continues after re-enable
        write_reg(1'b1, 32'h2 << SEL_LSB);
        write_reg(1'b0, 32'h0);
        check_window("R9", 0, 1'b1, 300);
        write_reg(1'b0, 32'h1);
        check_window("R9", SEL_LSB + 1, 1'b0, 400);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        checks++;
        if (beep_out !== 1'b0) begin
            errors++;
            $display("FAIL R10 stop actual %0b expected 0", beep_out);
        end
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_bit();
        t_period();
        t_field();
        t_multi();
        t_none();
        t_half();
        t_slow();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule